// File: doc/BRIEF.md
# Double-Buffered Pulse Width Modulator

This block drives one pulse width modulated output whose period stays fixed while its duty cycle is set by software. A prescaler divides the incoming clock into ticks; each tick advances a 16-bit period counter that runs from zero up to the programmed period minus one and then wraps. The output sits at its active level while the counter is below the active pulse width, so a width of zero gives a constantly inactive output and a width at or above the period gives a constantly active one.

Software writes a next pulse width into a shadow register. In buffered mode the shadow value moves into the active width only when the counter wraps, so a period never mixes two widths. In transparent mode a write to the shadow register also loads the active width on the same clock edge. A polarity bit swaps the output levels. A debug freeze input, honoured only when the freeze-enable bit is set, halts the prescaler and the counter and holds the output level.

A two-state run controller sets the halt. State RUN: ticks flow and the output register updates. State FROZEN: both stop. Transition RUN to FROZEN is taken when freeze-enable and the freeze input are both high; FROZEN to RUN is taken when either drops. The state changes one clock after its condition does.

Top module: `pwm_dbuf_top`

## Requirements
- R1: The counter takes period ticks per cycle, so with period P (1 to 65535, register offset 2) and divide ratio D the output repeats every P*D clocks and is active for min(W,P)*D clocks of each repetition, W being the active width.
- R2: A write of 0 to the period register (offset 2) is ignored and the previous period is kept.
- R3: A pulse width of 0 keeps the output at its inactive level for the whole period.
- R4: A pulse width equal to or greater than the period keeps the output at its active level through every wrap with no inactive clock.
- R5: The prescaler register (offset 1, bits 7:0) holds value V and divides the clock by V+1; V=0 produces a tick every clock.
- R6: Control bit 0 (offset 0) inverts the output: active level becomes 0 and inactive level becomes 1.
- R7: With control bit 1 clear, a write to the next-width register (offset 3) leaves the active width (readable at offset 4) unchanged until the counter wraps, and the wrap copies the next width into it.
- R8: With control bit 1 set, a write to the next-width register loads the active width on the same clock edge.
- R9: With control bit 2 set, a high freeze input stops the counter and holds the output level from one clock after it rises; with control bit 2 clear the freeze input has no effect.
- R10: Reset sets control to 0, prescaler to 0, period to RST_PERIOD (10), and both next and active width to INIT_WIDTH (3), so the output runs at that duty cycle before any write.
- R11: All registers at offsets 0 to 4 read back on rdata combinationally; offset 4 is read-only and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register offset for write and read |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for offset addr |
| dbg_freeze | input | 1 | Debug halt request |
| pwm_out | output | 1 | Modulated output |

## Verification
The hardest situation to reach is a shadow write that lands between two wraps, where buffered and transparent modes must give different active widths. The bench uses a long period, waits for the output to fall so the counter is known to be mid-period and far from the wrap, writes there and reads the active width at once and again after a full period. Freezing is checked by waiting for each output level before raising the freeze input, and the duty sweep keeps the freeze input high with freeze-enable clear to show it is ignored.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] OFS_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_PRESC  = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_PERIOD = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_NEXT   = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_ACTIVE = 3'd4;

    localparam int BIT_INVERT = 0;
    localparam int BIT_TRANSP = 1;
    localparam int BIT_FRZEN  = 2;

    typedef enum logic {
        ST_RUN    = 1'b0,
        ST_FROZEN = 1'b1
    } run_state_e;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_dbuf_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int PRE_W      = 8,
    parameter int RST_PERIOD = 10,
    parameter int INIT_WIDTH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    input  logic [CNT_W-1:0]  active_width,
    output logic              invert,
    output logic              transparent,
    output logic              freeze_en,
    output logic [PRE_W-1:0]  presc,
    output logic [CNT_W-1:0]  period,
    output logic [CNT_W-1:0]  next_width,
    output logic              next_wr
);
    logic wr_ctrl, wr_presc, wr_period;

    assign wr_ctrl   = wr_en && (addr == OFS_CTRL);
    assign wr_presc  = wr_en && (addr == OFS_PRESC);
    assign wr_period = wr_en && (addr == OFS_PERIOD) && (wdata != '0);
    assign next_wr   = wr_en && (addr == OFS_NEXT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            invert      <= 1'b0;
            transparent <= 1'b0;
            freeze_en   <= 1'b0;
            presc       <= '0;
            period      <= CNT_W'(RST_PERIOD);
            next_width  <= CNT_W'(INIT_WIDTH);
        end else begin
            if (wr_ctrl) begin
                invert      <= wdata[BIT_INVERT];
                transparent <= wdata[BIT_TRANSP];
                freeze_en   <= wdata[BIT_FRZEN];
            end
            if (wr_presc)  presc      <= wdata[PRE_W-1:0];
            if (wr_period) period     <= wdata;
            if (next_wr)   next_width <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            OFS_CTRL: begin
                rdata[BIT_INVERT] = invert;
                rdata[BIT_TRANSP] = transparent;
                rdata[BIT_FRZEN]  = freeze_en;
            end
            OFS_PRESC:  rdata[PRE_W-1:0] = presc;
            OFS_PERIOD: rdata = period;
            OFS_NEXT:   rdata = next_width;
            OFS_ACTIVE: rdata = active_width;
            default:    rdata = '0;
        endcase
    end

    AST_PERIOD_ZERO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_PERIOD && wdata == '0) |=> $stable(period)); // R2
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] div_sel,
    output logic             tick
);
    logic [PRE_W-1:0] pcnt_q;

    assign tick = run && (pcnt_q >= div_sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (run) begin
            pcnt_q <= tick ? '0 : pcnt_q + 1'b1;
        end
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_sel != '0) |=> (!tick || div_sel == '0)); // R5
endmodule

// File: rtl/pwm_core.sv
module pwm_core
    import pwm_dbuf_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int INIT_WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             dbg_freeze,
    input  logic             freeze_en,
    input  logic             transparent,
    input  logic             invert,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] next_width,
    input  logic             next_wr,
    input  logic [CNT_W-1:0] next_wdata,
    output logic [CNT_W-1:0] active_width,
    output logic             run,
    output logic             pwm_out
);
    run_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             wrap;
    logic             pwm_q;
    logic             halt_req;

    assign halt_req = freeze_en && dbg_freeze;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (halt_req)  state_d = ST_FROZEN;
            ST_FROZEN: if (!halt_req) state_d = ST_RUN;
            default:   state_d = ST_RUN;
        endcase
    end

    // outputs of the controller
    always_comb begin
        run = 1'b1;
        unique case (state_q)
            ST_RUN:    run = 1'b1;
            ST_FROZEN: run = 1'b0;
            default:   run = 1'b1;
        endcase
    end

    assign wrap = tick && (cnt_q >= period - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q        <= '0;
            active_width <= CNT_W'(INIT_WIDTH);
            pwm_q        <= 1'b0;
        end else begin
            if (tick) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
            if (next_wr && transparent) active_width <= next_wdata;
            else if (wrap)              active_width <= next_width;
            if (run) pwm_q <= (cnt_q < active_width) ^ invert;
        end
    end

    assign pwm_out = pwm_q;

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FROZEN) |=> $stable(pwm_out)); // R9
    AST_BUFFERED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap && !(next_wr && transparent)) |=> $stable(active_width)); // R7
    AST_TRANSPARENT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (next_wr && transparent) |=> (active_width == $past(next_wdata))); // R8
    AST_FROZEN_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FROZEN) |-> !tick); // R9
endmodule

// File: rtl/pwm_dbuf_top.sv
module pwm_dbuf_top
    import pwm_dbuf_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int PRE_W      = 8,
    parameter int RST_PERIOD = 10,
    parameter int INIT_WIDTH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    input  logic              dbg_freeze,
    output logic              pwm_out
);
    logic             invert, transparent, freeze_en, next_wr, run, tick;
    logic [PRE_W-1:0] presc;
    logic [CNT_W-1:0] period, next_width, active_width;

    pwm_regs #(
        .CNT_W(CNT_W), .PRE_W(PRE_W),
        .RST_PERIOD(RST_PERIOD), .INIT_WIDTH(INIT_WIDTH)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .active_width(active_width), .invert(invert),
        .transparent(transparent), .freeze_en(freeze_en), .presc(presc),
        .period(period), .next_width(next_width), .next_wr(next_wr)
    );

    pwm_prescaler #(.PRE_W(PRE_W)) presc_i (
        .clk(clk), .rst_n(rst_n), .run(run), .div_sel(presc), .tick(tick)
    );

    pwm_core #(.CNT_W(CNT_W), .INIT_WIDTH(INIT_WIDTH)) core_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .dbg_freeze(dbg_freeze),
        .freeze_en(freeze_en), .transparent(transparent), .invert(invert),
        .period(period), .next_width(next_width), .next_wr(next_wr),
        .next_wdata(wdata), .active_width(active_width), .run(run),
        .pwm_out(pwm_out)
    );
endmodule

// File: tb/pwm_dbuf_top_tb_top.sv
module pwm_dbuf_top_tb_top;
    localparam int RST_P = 10;
    localparam int INIT_W = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        dbg_freeze = 1'b0;
    logic        pwm_out;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pwm_dbuf_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .dbg_freeze(dbg_freeze), .pwm_out(pwm_out)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input int d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int d);
        addr = a;
        #1;
        d = int'(rdata);
    endtask

    task automatic count_high(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out) hi++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v, hi, lvl;
        bit stable;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset values
        rd(3'd0, v); check(v == 0, "R10 ctrl", v, 0);
        rd(3'd1, v); check(v == 0, "R10 presc", v, 0);
        rd(3'd2, v); check(v == RST_P, "R10 period", v, RST_P);
        rd(3'd3, v); check(v == INIT_W, "R10 next", v, INIT_W);
        rd(3'd4, v); check(v == INIT_W, "R10 active", v, INIT_W);
        repeat (5) @(negedge clk);
        count_high(RST_P, hi);
        check(hi == INIT_W, "R10 duty at reset", hi, INIT_W);

        // R11 readback, read-only active
        wr(3'd4, 7);
        rd(3'd4, v); check(v == INIT_W, "R11 active write ignored", v, INIT_W);
        wr(3'd1, 16'h01A5);
        rd(3'd1, v); check(v == 16'hA5, "R11 presc 8-bit", v, 16'hA5);
        wr(3'd0, 7);
        rd(3'd0, v); check(v == 7, "R11 ctrl", v, 7);
        wr(3'd0, 0);
        wr(3'd1, 0);

        // R2 period zero ignored
        wr(3'd2, 6);
        wr(3'd2, 0);
        rd(3'd2, v); check(v == 6, "R2 zero period ignored", v, 6);

        // R1 R3 R4 R5 R6 sweep; freeze input high with freeze disabled (R9)
        dbg_freeze = 1'b1;
        for (int inv = 0; inv < 2; inv++) begin
            wr(3'd0, inv);
            for (int d = 1; d <= 3; d++) begin
                wr(3'd1, d - 1);
                for (int p = 1; p <= 4; p++) begin
                    wr(3'd2, p);
                    for (int w = 0; w <= p + 1; w++) begin
                        int per, exp_hi;
                        string tag;
                        wr(3'd3, w);
                        per = p * d;
                        repeat (3 * per + 4) @(negedge clk);
                        count_high(per, hi);
                        exp_hi = ((w < p) ? w : p) * d;
                        if (inv != 0) exp_hi = per - exp_hi;
                        tag = (w == 0) ? "R3" : ((w >= p) ? "R4" : "R1");
                        if (d > 1) tag = {tag, " R5"};
                        if (inv != 0) tag = {tag, " R6"};
                        tag = {tag, " R9 ignored"};
                        check(hi == exp_hi, tag, hi, exp_hi);
                    end
                end
            end
        end
        dbg_freeze = 1'b0;

        // R7 buffered transfer
        wr(3'd0, 0);
        wr(3'd1, 0);
        wr(3'd2, 200);
        wr(3'd3, 50);
        repeat (450) @(negedge clk);
        while (pwm_out) @(negedge clk);
        wr(3'd3, 120);
        rd(3'd4, v); check(v == 50, "R7 active held before wrap", v, 50);
        repeat (210) @(negedge clk);
        rd(3'd4, v); check(v == 120, "R7 active loaded at wrap", v, 120);

        // R8 transparent
        wr(3'd0, 2);
        while (pwm_out) @(negedge clk);
        wr(3'd3, 30);
        rd(3'd4, v); check(v == 30, "R8 transparent load", v, 30);

        // R9 freeze holds level, both levels
        wr(3'd0, 4);
        wr(3'd2, 20);
        wr(3'd3, 10);
        repeat (50) @(negedge clk);
        for (int want = 1; want >= 0; want--) begin
            while (pwm_out != want[0]) @(negedge clk);
            dbg_freeze = 1'b1;
            @(negedge clk);
            @(negedge clk);
            lvl = int'(pwm_out);
            stable = 1'b1;
            for (int i = 0; i < 60; i++) begin
                @(negedge clk);
                if (int'(pwm_out) != lvl) stable = 1'b0;
            end
            check(stable, "R9 output held while frozen", int'(stable), 1);
            dbg_freeze = 1'b0;
        end
        repeat (50) @(negedge clk);
        count_high(20, hi);
        check(hi == 10, "R9 duty after release", hi, 10);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule